// File: doc/BRIEF.md
# Block Memory Copy Engine

The engine moves a run of bytes from one region of a byte-addressed memory to another. Software, or a neighbouring controller, presents a source pointer, a destination pointer, a 16-bit byte counter and the current values of three status flags, then pulses `start`. Two mode bits are sampled with that pulse. One chooses whether the pointers walk upward or downward. The other chooses between a single transfer and a transfer that repeats until the counter runs out.

Every iteration takes two clocks on a simple synchronous memory port. In the first clock the engine reads at the source pointer. In the second it writes the returned byte at the destination pointer. On the edge that ends the write, both pointers step by one, the counter drops by one, and the flags are rewritten. The updated pointers, counter and flags stay on the outputs for the caller. A one-clock `done` pulse follows the last write. While `busy` is high, the engine ignores any further start pulse.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low, and `src_ptr`, `dst_ptr`, `count` and `flags` are all zero.
- R2: Each iteration raises `mem_rd` for one clock with `mem_addr` equal to `src_ptr`. In the next clock it raises `mem_wr` with `mem_addr` equal to `dst_ptr` and `mem_wdata` equal to the byte read. The two strobes are never high together.
- R3: When `dec_mode` is 0 at start, both pointers rise by 1 after each write. When it is 1, both fall by 1. Both wrap modulo 2^16.
- R4: `count` falls by 1 after each write and wraps modulo 2^16, so 0x0000 becomes 0xFFFF.
- R5: `flags` is encoded as bit 2 = parity/overflow, bit 1 = half-carry, bit 0 = add/subtract. After each write, bits 1 and 0 are 0, and bit 2 is 1 exactly when the new `count` is nonzero.
- R6: With `repeat_mode` 0 at start, exactly one iteration takes place, whatever the counter value.
- R7: With `repeat_mode` 1 and a nonzero counter N at start, exactly N iterations take place, ending with `count` equal to 0.
- R8: With `repeat_mode` 1 and a counter of 0 at start, 65536 iterations take place, and both pointers end at their starting values.
- R9: `done` is high for exactly one clock, in the clock after the last write. `busy` is high from the clock after the start pulse until the last write completes, and it is never high together with `done`.
- R10: A start pulse while `busy` is high has no effect on the transfer, the pointers, the counter or the flags.
- R11: A start pulse accepted while `busy` is low loads `src_init`, `dst_init`, `cnt_init` and `flags_init`. These values appear on the outputs in the clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin a transfer |
| dec_mode | input | 1 | 1 = pointers decrement, 0 = increment; sampled with start |
| repeat_mode | input | 1 | 1 = repeat until counter is zero, 0 = single iteration; sampled with start |
| src_init | input | 16 | Source pointer loaded at start |
| dst_init | input | 16 | Destination pointer loaded at start |
| cnt_init | input | 16 | Byte counter loaded at start |
| flags_init | input | 3 | Flag values loaded at start (encoding as in R5) |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data returns in the next clock |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_rd` |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Current byte counter |
| flags | output | 3 | Current flags (encoding as in R5) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse after the final write |

## Verification
The assertions assume that the memory returns read data exactly one clock after `mem_rd` and never stalls. They also assume that `start` is a synchronous level that the engine samples only on clock edges. The bench's memory model has that fixed one-clock read latency and no wait states. It drives `start`, the modes and the initial values away from the active edge and holds them stable across it. The bench injects start pulses only while the engine is busy or idle, never asynchronously. It keeps its pointers within a 256-byte aliased window, so the model's addresses stay well defined even when a run wraps past 0xFFFF.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } copy_state_t;

    typedef struct packed {
        logic pv;
        logic half;
        logic sub;
    } copy_flags_t;

    localparam int unsigned PTR_SRC = 0;
    localparam int unsigned PTR_DST = 1;
    localparam int unsigned NUM_PTR = 2;

    function automatic copy_flags_t iter_flags(input logic cnt_nonzero);
        copy_flags_t f;
        f.pv   = cnt_nonzero;
        f.half = 1'b0;
        f.sub  = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
    import blkcopy_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rep_q,
    input  logic        last_iter,
    output copy_state_t state,
    output logic        load,
    output logic        step
);
    copy_state_t state_d;
    logic        idle_like;

    assign idle_like = (state == ST_IDLE) || (state == ST_FIN);
    assign load      = start && idle_like;
    assign step      = (state == ST_WRITE);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE, ST_FIN: state_d = start ? ST_READ : ST_IDLE;
            ST_READ:         state_d = ST_WRITE;
            ST_WRITE:        state_d = (rep_q && !last_iter) ? ST_READ : ST_FIN;
            default:         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/blkcopy_ptrs.sv
module blkcopy_ptrs
    import blkcopy_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              dec_in,
    input  logic              rep_in,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              dir_q,
    output logic              rep_q
);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] ptr_init [NUM_PTR];
    logic [ADDR_W-1:0] ptr_q    [NUM_PTR];

    assign ptr_init[PTR_SRC] = src_init;
    assign ptr_init[PTR_DST] = dst_init;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic [ADDR_W-1:0] stepped;
        assign stepped = dir_q ? (ptr_q[g] - A_ONE) : (ptr_q[g] + A_ONE);
        always_ff @(posedge clk) begin
            if (rst)       ptr_q[g] <= '0;
            else if (load) ptr_q[g] <= ptr_init[g];
            else if (step) ptr_q[g] <= stepped;
        end
    end

    assign src_q    = ptr_q[PTR_SRC];
    assign dst_q    = ptr_q[PTR_DST];
    assign cnt_next = cnt_q - C_ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
            rep_q <= 1'b0;
        end else if (load) begin
            cnt_q <= cnt_init;
            dir_q <= dec_in;
            rep_q <= rep_in;
        end else if (step) begin
            cnt_q <= cnt_next;
        end
    end
endmodule

// File: rtl/blkcopy_flagunit.sv
module blkcopy_flagunit
    import blkcopy_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        step,
    input  copy_flags_t seed,
    input  logic        cnt_nonzero,
    output copy_flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst)       flags_q <= '0;
        else if (load) flags_q <= seed;
        else if (step) flags_q <= iter_flags(cnt_nonzero);
    end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dec_mode,
    input  logic              repeat_mode,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    input  logic [2:0]        flags_init,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [2:0]        flags,
    output logic              busy,
    output logic              done
);
    copy_state_t      state;
    logic             load;
    logic             step;
    logic             dir_q;
    logic             rep_q;
    logic [CNT_W-1:0] cnt_next;
    logic             next_nonzero;
    copy_flags_t      flags_q;

    assign next_nonzero = |cnt_next;

    blkcopy_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rep_q     (rep_q),
        .last_iter (!next_nonzero),
        .state     (state),
        .load      (load),
        .step      (step)
    );

    blkcopy_ptrs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .dec_in   (dec_mode),
        .rep_in   (repeat_mode),
        .src_init (src_init),
        .dst_init (dst_init),
        .cnt_init (cnt_init),
        .src_q    (src_ptr),
        .dst_q    (dst_ptr),
        .cnt_q    (count),
        .cnt_next (cnt_next),
        .dir_q    (dir_q),
        .rep_q    (rep_q)
    );

    blkcopy_flagunit u_flags (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .step        (step),
        .seed        (copy_flags_t'(flags_init)),
        .cnt_nonzero (next_nonzero),
        .flags_q     (flags_q)
    );

    assign flags     = flags_q;
    assign mem_rd    = (state == ST_READ);
    assign mem_wr    = (state == ST_WRITE);
    assign mem_addr  = mem_wr ? dst_ptr : src_ptr;
    assign mem_wdata = mem_rdata;
    assign busy      = mem_rd || mem_wr;
    assign done      = (state == ST_FIN);
endmodule

// File: rtl/blkcopy_checker.sv
module blkcopy_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] src_ptr,
    input logic [ADDR_W-1:0] dst_ptr,
    input logic [CNT_W-1:0]  count,
    input logic [2:0]        flags,
    input logic              dir_q
);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);
    a_r2_read_addr: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> mem_addr == src_ptr);
    a_r2_write_addr: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr == dst_ptr);
    a_r3_src_step: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> src_ptr == ($past(dir_q) ? $past(src_ptr) - A_ONE : $past(src_ptr) + A_ONE));
    a_r3_dst_step: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> dst_ptr == ($past(dir_q) ? $past(dst_ptr) - A_ONE : $past(dst_ptr) + A_ONE));
    a_r4_count_dec: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> count == $past(count) - C_ONE);
    a_r5_flags: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> flags == {(count != '0), 2'b00});
    a_r9_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_wr));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_busy_done: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    a_r10_hold_in_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> $stable(src_ptr) && $stable(dst_ptr) && $stable(count) && $stable(flags));
endmodule

bind blkcopy_engine blkcopy_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .src_ptr  (src_ptr),
    .dst_ptr  (dst_ptr),
    .count    (count),
    .flags    (flags),
    .dir_q    (dir_q)
);

// File: tb/blkcopy_engine_test.sv
module blkcopy_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dec_mode = 1'b0;
    logic        repeat_mode = 1'b0;
    logic [15:0] src_init = '0;
    logic [15:0] dst_init = '0;
    logic [15:0] cnt_init = '0;
    logic [2:0]  flags_init = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] src_ptr;
    logic [15:0] dst_ptr;
    logic [15:0] count;
    logic [2:0]  flags;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];

    always #10 clk = ~clk;

    blkcopy_engine uut (
        .clk(clk), .rst(rst), .start(start), .dec_mode(dec_mode),
        .repeat_mode(repeat_mode), .src_init(src_init), .dst_init(dst_init),
        .cnt_init(cnt_init), .flags_init(flags_init), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .count(count), .flags(flags), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog R9: actual=no completion expected=done within budget");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint expv);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic run_copy(
        input  logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
        input  logic dec, input logic rep, input logic [2:0] seed,
        input  logic inject, output int iters);
        logic [15:0] es = s;
        logic [15:0] ed = d;
        int   data_errs = 0;
        int   hs_errs   = 0;
        logic last_wr   = 1'b0;
        logic injected  = 1'b0;
        iters = 0;
        @(negedge clk);
        src_init = s; dst_init = d; cnt_init = c;
        dec_mode = dec; repeat_mode = rep; flags_init = seed; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(src_ptr == s && dst_ptr == d, "R11 pointers loaded", {src_ptr, dst_ptr}, {s, d});
        check(count == c && flags == seed, "R11 counter/flags loaded", {count, 13'(0), flags}, {c, 13'(0), seed});
        forever begin
            if (done) break;
            if (!busy) hs_errs++;
            if (mem_rd && mem_addr !== es) data_errs++;
            if (mem_wr) begin
                if (mem_addr !== ed || mem_wdata !== exp_mem[es[7:0]]) data_errs++;
                exp_mem[ed[7:0]] = exp_mem[es[7:0]];
                es = dec ? es - 16'd1 : es + 16'd1;
                ed = dec ? ed - 16'd1 : ed + 16'd1;
                iters++;
            end
            last_wr = mem_wr;
            if (inject && mem_rd && !injected) begin
                injected = 1'b1;
                src_init = 16'h00AA; dst_init = 16'h00BB; cnt_init = 16'h0007;
                flags_init = 3'b011; dec_mode = ~dec; repeat_mode = ~rep;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                continue;
            end
            @(negedge clk);
        end
        if (busy || !last_wr) hs_errs++;
        @(negedge clk);
        if (done) hs_errs++;
        check(data_errs == 0, "R2 read/write addresses and data", data_errs, 0);
        check(hs_errs == 0, "R9 busy/done handshake", hs_errs, 0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !mem_rd && !mem_wr, "R1 control outputs after reset",
              {busy, done, mem_rd, mem_wr}, 0);
        check(src_ptr == 0 && dst_ptr == 0 && count == 0 && flags == 0,
              "R1 state after reset", {src_ptr, dst_ptr, count, 13'(0), flags}, 0);
    endtask

    task automatic t_single_inc();
        int it;
        run_copy(16'h0010, 16'h0080, 16'h0005, 1'b0, 1'b0, 3'b111, 1'b0, it);
        check(it == 1, "R6 single iteration", it, 1);
        check(src_ptr == 16'h0011 && dst_ptr == 16'h0081, "R3 increment step",
              {src_ptr, dst_ptr}, {16'h0011, 16'h0081});
        check(count == 16'h0004, "R4 counter decrement", count, 16'h0004);
        check(flags == 3'b100, "R5 flags with nonzero counter", flags, 3'b100);
    endtask

    task automatic t_single_to_zero();
        int it;
        run_copy(16'h0030, 16'h0031, 16'h0001, 1'b0, 1'b0, 3'b111, 1'b0, it);
        check(count == 16'h0000, "R4 counter reaches zero", count, 0);
        check(flags == 3'b000, "R5 flags with zero counter", flags, 3'b000);
    endtask

    task automatic t_single_wrap();
        int it;
        run_copy(16'h0000, 16'h0040, 16'h0000, 1'b1, 1'b0, 3'b001, 1'b0, it);
        check(it == 1, "R6 single iteration with zero counter", it, 1);
        check(src_ptr == 16'hFFFF && dst_ptr == 16'h003F, "R3 decrement wraps",
              {src_ptr, dst_ptr}, {16'hFFFF, 16'h003F});
        check(count == 16'hFFFF, "R4 counter wraps", count, 16'hFFFF);
        check(flags == 3'b100, "R5 flags after wrap", flags, 3'b100);
    endtask

    task automatic t_repeat_inc();
        int it;
        run_copy(16'h0020, 16'h0060, 16'h0006, 1'b0, 1'b1, 3'b010, 1'b0, it);
        check(it == 6, "R7 repeat increment iterations", it, 6);
        check(src_ptr == 16'h0026 && dst_ptr == 16'h0066 && count == 0,
              "R7 repeat increment end state", {src_ptr, dst_ptr, count}, {16'h0026, 16'h0066, 16'h0});
        check(flags == 3'b000, "R5 flags after repeat", flags, 0);
    endtask

    task automatic t_repeat_dec();
        int it;
        run_copy(16'h00F3, 16'h00D3, 16'h0004, 1'b1, 1'b1, 3'b000, 1'b0, it);
        check(it == 4, "R7 repeat decrement iterations", it, 4);
        check(src_ptr == 16'h00EF && dst_ptr == 16'h00CF, "R3 repeat decrement pointers",
              {src_ptr, dst_ptr}, {16'h00EF, 16'h00CF});
    endtask

    task automatic t_busy_start();
        int it;
        run_copy(16'h0050, 16'h0090, 16'h0003, 1'b0, 1'b1, 3'b000, 1'b1, it);
        check(it == 3, "R10 start while busy keeps iteration count", it, 3);
        check(src_ptr == 16'h0053 && dst_ptr == 16'h0093 && count == 0,
              "R10 start while busy keeps state", {src_ptr, dst_ptr, count}, {16'h0053, 16'h0093, 16'h0});
    endtask

    task automatic t_repeat_zero();
        int it;
        run_copy(16'h1234, 16'h5678, 16'h0000, 1'b0, 1'b1, 3'b000, 1'b0, it);
        check(it == 65536, "R8 zero counter repeat iterations", it, 65536);
        check(src_ptr == 16'h1234 && dst_ptr == 16'h5678 && count == 0,
              "R8 pointers back to start", {src_ptr, dst_ptr, count}, {16'h1234, 16'h5678, 16'h0});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_inc();
        t_single_to_zero();
        t_single_wrap();
        t_repeat_inc();
        t_repeat_dec();
        t_busy_start();
        t_repeat_zero();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule